// File: doc/BRIEF.md
# Two-Phase Incrementing Program Counter

This block holds the address of the current instruction for a small processor. Two storage stages run on opposite clock phases. The output stage holds the current address. That address feeds a ripple chain of half adders, and the chain's carry-in serves as the count enable. The input stage picks its next value on the rising edge from one of three sources: all zeros, a word taken from the shared bus, or the adder result. The output stage copies the input stage on the following falling edge. A request made before a rising edge therefore shows on the address output after the next falling edge.

Three named sources drive the selection network: SRC_CLEAR (reset high), SRC_LOAD (load high, reset low) and SRC_STEP (both low). When the selection is SRC_STEP, the adder result is taken, so the address advances when count enable is high and holds when it is low. The selection is re-evaluated every cycle, so any source can follow any other. The current address can also be placed on the shared bus under an output enable, so that it can be moved into an address register. The block drives the bus in open-drain style: it presents the address together with a drive flag, and it presents all zeros with the flag low when released.

Top module: `pc_two_phase`

## Requirements
- R1: The address output changes only on a falling clock edge. A value captured at a rising edge appears on the address output at the next falling edge and not before.
- R2: When reset is high at a rising edge, the address becomes 4'b0000 at the following falling edge.
- R3: When load is high and reset is low at a rising edge, the address becomes the 4-bit bus input value, whatever the count enable is.
- R4: When reset and load are both high, reset wins and the address becomes 4'b0000.
- R5: When reset and load are low and count enable is high, the address advances by exactly one per clock cycle.
- R6: When reset, load and count enable are all low, the address holds its value.
- R7: Advancing from 4'b1111 gives 4'b0000, and the carry out of the top bit is discarded.
- R8: When output enable is high, the bus drive flag is 1 and the bus data output equals the current address.
- R9: When output enable is low, the bus drive flag is 0 and the bus data output is all zeros, which releases the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the input stage captures on the rising edge, the output stage on the falling edge |
| rst | input | 1 | Synchronous clear of the input stage (highest priority) |
| cen | input | 1 | Count enable, wired to the carry-in of the adder chain |
| load | input | 1 | Take the next address from the bus |
| oe | input | 1 | Place the current address on the bus |
| bus_in | input | 4 | Word read from the shared bus |
| pc_q | output | 4 | Current address (output stage) |
| bus_data | output | 4 | Address while driving, zeros while released |
| bus_en | output | 1 | Bus drive flag |

## Verification
A wrong value in the input stage reaches the address output at the very next falling edge, half a cycle after the rising edge that captured it. A wrong selection, such as load winning over reset or the adder used while load is high, appears within one cycle. A broken carry in the adder chain shows only at certain counts, so the counting run checks every step and covers the wrap from 15 to 0. Bus faults show at once on the combinational bus outputs when output enable changes.

// File: rtl/pc_pkg.sv
package pc_pkg;
    localparam int PC_W = 4;

    typedef enum logic [1:0] {
        SRC_CLEAR = 2'd0,
        SRC_LOAD  = 2'd1,
        SRC_STEP  = 2'd2
    } pc_src_t;
endpackage

// File: rtl/pc_ha_chain.sv
module pc_ha_chain #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic         cin,
    output logic [W-1:0] sum
);
    logic [W-1:0] carry;

    assign carry[0] = cin;

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum[i] = a[i] ^ carry[i];
            if (i < W - 1) begin : g_carry
                assign carry[i+1] = a[i] & carry[i];
            end
        end
    endgenerate
endmodule

// File: rtl/pc_next_sel.sv
module pc_next_sel
    import pc_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] bus_in,
    input  logic [W-1:0] adder_sum,
    output pc_src_t      src,
    output logic [W-1:0] next_val
);
    always_comb begin
        if (rst)       src = SRC_CLEAR;
        else if (load) src = SRC_LOAD;
        else           src = SRC_STEP;
    end

    always_comb begin
        unique case (src)
            SRC_CLEAR: next_val = '0;
            SRC_LOAD:  next_val = bus_in;
            SRC_STEP:  next_val = adder_sum;
            default:   next_val = '0;
        endcase
    end
endmodule

// File: rtl/pc_bus_drv.sv
module pc_bus_drv #(
    parameter int W = 4
) (
    input  logic [W-1:0] addr,
    input  logic         oe,
    output logic [W-1:0] bus_data,
    output logic         bus_en
);
    assign bus_en   = oe;
    assign bus_data = oe ? addr : '0;
endmodule

// File: rtl/pc_two_phase.sv
module pc_two_phase
    import pc_pkg::*;
#(
    parameter int W = PC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cen,
    input  logic         load,
    input  logic         oe,
    input  logic [W-1:0] bus_in,
    output logic [W-1:0] pc_q,
    output logic [W-1:0] bus_data,
    output logic         bus_en
);
    logic [W-1:0] stage_in;
    logic [W-1:0] stage_out;
    logic [W-1:0] adder_sum;
    logic [W-1:0] next_val;
    pc_src_t      src;

    pc_ha_chain #(.W(W)) u_chain (
        .a   (stage_out),
        .cin (cen),
        .sum (adder_sum)
    );

    pc_next_sel #(.W(W)) u_sel (
        .rst       (rst),
        .load      (load),
        .bus_in    (bus_in),
        .adder_sum (adder_sum),
        .src       (src),
        .next_val  (next_val)
    );

    // Input stage: captures on the high phase
    always_ff @(posedge clk) begin
        stage_in <= next_val;
    end

    // Output stage: presents to the adder during the low phase
    always_ff @(negedge clk) begin
        stage_out <= stage_in;
    end

    assign pc_q = stage_out;

    pc_bus_drv #(.W(W)) u_drv (
        .addr     (stage_out),
        .oe       (oe),
        .bus_data (bus_data),
        .bus_en   (bus_en)
    );

    AST_CLEAR_WINS: assert property (@(posedge clk) rst |=> (stage_in == '0)); // R4
    AST_LOAD_TAKES_BUS: assert property (@(posedge clk) disable iff (rst)
        load |=> (stage_in == $past(bus_in))); // R3
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (!load && cen) |=> (stage_in == W'($past(stage_out) + W'(1)))); // R5
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!load && !cen) |=> (stage_in == $past(stage_out))); // R6
    AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        stage_out == stage_in); // R1
    AST_BUS_RELEASED: assert property (@(posedge clk) disable iff (rst)
        !oe |-> (bus_data == '0 && !bus_en)); // R9
    AST_BUS_DRIVEN: assert property (@(posedge clk) disable iff (rst)
        oe |-> (bus_data == pc_q && bus_en)); // R8
endmodule

// File: tb/sim_pc_two_phase.sv
`timescale 1ns/100ps
module sim_pc_two_phase;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cen = 1'b0;
    logic       load = 1'b0;
    logic       oe = 1'b0;
    logic [3:0] bus_in = 4'd0;
    logic [3:0] pc_q;
    logic [3:0] bus_data;
    logic       bus_en;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    pc_two_phase u0 (
        .clk(clk), .rst(rst), .cen(cen), .load(load), .oe(oe),
        .bus_in(bus_in), .pc_q(pc_q), .bus_data(bus_data), .bus_en(bus_en)
    );

    task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one full cycle: rising edge captures, falling edge updates; sample after it
    task automatic cycle();
        @(posedge clk); @(negedge clk); #1;
    endtask

    task automatic t_reset();
        rst = 1'b1; load = 1'b1; bus_in = 4'hA; cen = 1'b1;
        cycle(); cycle();
        chk("R2 reset clears", {1'b0, pc_q}, 5'h00);
        chk("R4 reset beats load", {1'b0, pc_q}, 5'h00);
        rst = 1'b0; load = 1'b0; cen = 1'b0;
    endtask

    task automatic t_count();
        cen = 1'b1;
        for (int i = 1; i <= 6; i++) begin
            cycle();
            chk("R5 step", {1'b0, pc_q}, 5'(i));
        end
        cen = 1'b0;
    endtask

    task automatic t_hold();
        logic [3:0] was;
        was = pc_q;
        for (int i = 0; i < 3; i++) begin
            cycle();
            chk("R6 hold", {1'b0, pc_q}, {1'b0, was});
        end
    endtask

    task automatic t_phase();
        logic [3:0] was;
        was = pc_q; cen = 1'b1;
        @(posedge clk); #1;
        chk("R1 no change on rising edge", {1'b0, pc_q}, {1'b0, was});
        cen = 1'b0;
        @(negedge clk); #1;
        chk("R1 change on falling edge", {1'b0, pc_q}, {1'b0, 4'(was + 4'd1)});
    endtask

    task automatic t_load(input logic [3:0] v, input logic en);
        load = 1'b1; bus_in = v; cen = en;
        cycle();
        chk("R3 load", {1'b0, pc_q}, {1'b0, v});
        load = 1'b0; cen = 1'b0;
    endtask

    task automatic t_wrap();
        t_load(4'hE, 1'b0);
        cen = 1'b1;
        cycle(); chk("R7 reach 15", {1'b0, pc_q}, 5'h0F);
        cycle(); chk("R7 wrap to 0", {1'b0, pc_q}, 5'h00);
        cycle(); chk("R7 after wrap", {1'b0, pc_q}, 5'h01);
        cen = 1'b0;
    endtask

    task automatic t_bus();
        t_load(4'h9, 1'b1);
        oe = 1'b1; #1;
        chk("R8 drive data", {1'b0, bus_data}, 5'h09);
        chk("R8 drive flag", {4'b0, bus_en}, 5'h01);
        oe = 1'b0; #1;
        chk("R9 release data", {1'b0, bus_data}, 5'h00);
        chk("R9 release flag", {4'b0, bus_en}, 5'h00);
        chk("R9 address kept", {1'b0, pc_q}, 5'h09);
    endtask

    task automatic t_mid_reset();
        load = 1'b1; bus_in = 4'h7; cycle();
        rst = 1'b1; load = 1'b1; bus_in = 4'h3; cycle();
        chk("R4 reset over load mid-run", {1'b0, pc_q}, 5'h00);
        rst = 1'b0; load = 1'b0;
    endtask

    initial begin
        #100000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk); #1;
        t_reset();
        t_count();
        t_hold();
        t_phase();
        t_load(4'h5, 1'b1);
        t_load(4'hC, 1'b0);
        t_hold();
        t_wrap();
        t_bus();
        t_mid_reset();
        t_count();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule